// File: doc/BRIEF.md
# Mixed-Width Indirect Jump Unit

This block watches a byte-wide instruction stream and picks out the register-indirect jump through one of two 24-bit index registers. The jump may carry a width-override prefix byte in front of it. When a complete jump is decoded, the block loads its program counter from the selected index register. It also produces the new addressing-mode bit, which selects between 16-bit and 24-bit addressing, and reports how many cycles the jump form takes.

In 16-bit mode the fetch address is the 16-bit PC with an 8-bit memory base register placed above it. In 24-bit mode the fetch address is the full PC. The enclosing core normally feeds the mode output back into the mode input, and the block samples that input on the cycle the final opcode byte is accepted.

The byte input is a valid/ready stream. Outside reset, `in_ready` is held high, so the block applies no back-pressure. A byte is consumed only on a cycle where both `in_valid` and `in_ready` are high. The source may leave idle gaps of any length with `in_valid` low, and the decoder holds its state across them.

Top module: `ijmp_unit`

## Requirements
- R1: A synchronous reset clears the PC to 0, clears the mode output to 0, drops `jump_taken`, holds `in_ready` low and returns the decoder to idle, so a half-received sequence is discarded.
- R2: The byte pair 0xDD, 0xE9 jumps through `idx_a`, and the pair 0xFD, 0xE9 jumps through `idx_b`.
- R3: With the sampled mode 0 and either no prefix or the short prefix 0x40, only PC[15:0] is loaded from the index register's low 16 bits, PC[23:16] is left unchanged, and the mode stays 0.
- R4: With the sampled mode 1 and either no prefix or the long prefix 0x5B, all 24 PC bits are loaded and the mode stays 1.
- R5: With the sampled mode 0 and the long prefix 0x5B, all 24 PC bits are loaded and the mode becomes 1.
- R6: With the sampled mode 1 and the short prefix 0x40, only PC[15:0] is loaded, PC[23:16] is kept, and the mode becomes 0.
- R7: `fetch_addr` equals `{base_reg, pc[15:0]}` while `mode_out` is 0, and equals `pc` while `mode_out` is 1.
- R8: `jump_taken` is high for exactly the one cycle after the 0xE9 byte is accepted. In that cycle the new PC and mode are visible, and `jump_cycles` reads 4 for the unprefixed form or 5 for a prefixed form.
- R9: A sequence that breaks the pattern (optional prefix, then 0xDD or 0xFD, then 0xE9) sends the decoder back to idle. The offending byte is dropped and is not re-interpreted. PC and mode are unchanged, and no strobe is raised.
- R10: Cycles with `in_valid` low consume nothing and change neither the decoder state nor the PC. `in_ready` is high on every cycle outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte is present |
| in_ready | output | 1 | Block accepts a byte (high outside reset) |
| in_data | input | 8 | Instruction byte |
| idx_a | input | 24 | First index register value |
| idx_b | input | 24 | Second index register value |
| base_reg | input | 8 | Memory base used in 16-bit mode |
| mode_in | input | 1 | Current addressing mode (1 = 24-bit) |
| pc | output | 24 | Program counter |
| fetch_addr | output | 24 | Effective fetch address |
| mode_out | output | 1 | Addressing mode after the last jump |
| jump_taken | output | 1 | One-cycle strobe for a completed jump |
| jump_cycles | output | 3 | Cycle count of the last jump form |

## Verification
The assertions assume that reset is held high from the first clock edge. They also assume that `in_data` and `mode_in` are settled whenever `in_valid` is high at an edge. They rely on the decoder never completing two jumps on back-to-back cycles, which holds because a jump needs at least two accepted bytes. The stimulus changes every input only on the falling clock edge. It starts with reset asserted, and it picks bytes mostly from the prefix, selector and final opcode values so that partial, doubled and broken sequences occur often. Each jump is checked under a freshly randomized `mode_in`, base and index values.

// File: rtl/ijmp_pkg.sv
package ijmp_pkg;
  localparam logic [7:0] OP_PFX_SHORT = 8'h40;
  localparam logic [7:0] OP_PFX_LONG  = 8'h5B;
  localparam logic [7:0] OP_SEL_A     = 8'hDD;
  localparam logic [7:0] OP_SEL_B     = 8'hFD;
  localparam logic [7:0] OP_JUMP      = 8'hE9;

  localparam int CYC_W     = 3;
  localparam int CYC_PLAIN = 4;
  localparam int CYC_PFX   = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PFX  = 2'd1,
    ST_SEL  = 2'd2
  } dec_st_e;

  typedef enum logic [1:0] {
    PFX_NONE  = 2'd0,
    PFX_SHORT = 2'd1,
    PFX_LONG  = 2'd2
  } pfx_e;
endpackage

// File: rtl/ijmp_decoder.sv
module ijmp_decoder
  import ijmp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              fire,
  output logic              fire_use_b,
  output pfx_e              fire_pfx
);
  dec_st_e state_q, state_d;
  pfx_e    pfx_q, pfx_d;
  logic    sel_b_q, sel_b_d;
  logic    accept;
  logic    is_sel;

  assign in_ready = !rst;
  assign accept   = in_valid && in_ready;
  assign is_sel   = (in_data == OP_SEL_A) || (in_data == OP_SEL_B);

  always_comb begin
    state_d = state_q;
    pfx_d   = pfx_q;
    sel_b_d = sel_b_q;
    fire    = 1'b0;
    if (accept) begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_data == OP_PFX_SHORT) begin
            state_d = ST_PFX;
            pfx_d   = PFX_SHORT;
          end else if (in_data == OP_PFX_LONG) begin
            state_d = ST_PFX;
            pfx_d   = PFX_LONG;
          end else if (is_sel) begin
            state_d = ST_SEL;
            pfx_d   = PFX_NONE;
            sel_b_d = (in_data == OP_SEL_B);
          end
        end
        ST_PFX: begin
          if (is_sel) begin
            state_d = ST_SEL;
            sel_b_d = (in_data == OP_SEL_B);
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_SEL: begin
          state_d = ST_IDLE;
          fire    = (in_data == OP_JUMP);
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign fire_use_b = sel_b_q;
  assign fire_pfx   = pfx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pfx_q   <= PFX_NONE;
      sel_b_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pfx_q   <= pfx_d;
      sel_b_q <= sel_b_d;
    end
  end

  // R8: a jump needs at least two bytes, so completions never abut
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

  // R10: an idle input cycle leaves the decoder where it was
  a_r10_stall_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(state_q));
endmodule

// File: rtl/ijmp_pcgen.sv
module ijmp_pcgen
  import ijmp_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              use_b,
  input  pfx_e              pfx,
  input  logic              mode_in,
  input  logic [ADDR_W-1:0] idx_a,
  input  logic [ADDR_W-1:0] idx_b,
  output logic [ADDR_W-1:0] pc_q,
  output logic              mode_q,
  output logic              taken_q,
  output logic [CYC_W-1:0]  cyc_q
);
  localparam int UPPER_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] src;
  logic              go_long;
  logic [ADDR_W-1:0] pc_next;

  assign src     = use_b ? idx_b : idx_a;
  assign go_long = (pfx == PFX_LONG) || (mode_in && (pfx != PFX_SHORT));

  generate
    if (UPPER_W > 0) begin : g_split
      assign pc_next = go_long ? src : {pc_q[ADDR_W-1:SHORT_W], src[SHORT_W-1:0]};
    end else begin : g_flat
      assign pc_next = src;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      mode_q  <= 1'b0;
      taken_q <= 1'b0;
      cyc_q   <= '0;
    end else begin
      taken_q <= fire;
      if (fire) begin
        pc_q   <= pc_next;
        mode_q <= go_long;
        cyc_q  <= (pfx == PFX_NONE) ? CYC_W'(CYC_PLAIN) : CYC_W'(CYC_PFX);
      end
    end
  end

  // R3 / R6: a short-form jump never alters the upper PC bits
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (fire && (pfx == PFX_SHORT || (pfx == PFX_NONE && !mode_in)))
      |=> (pc_q[ADDR_W-1:SHORT_W] == $past(pc_q[ADDR_W-1:SHORT_W])));

  // R9: without a completed jump, PC and mode hold
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(pc_q) && $stable(mode_q)));

  // R8: the reported cycle count is one of the two legal forms
  a_r8_cycle_range: assert property (@(posedge clk) disable iff (rst)
    taken_q |-> (cyc_q == CYC_W'(CYC_PLAIN) || cyc_q == CYC_W'(CYC_PFX)));

  // R5: a long prefix always leaves 24-bit mode behind it
  a_r5_long_sets_mode: assert property (@(posedge clk) disable iff (rst)
    (fire && pfx == PFX_LONG) |=> mode_q);
endmodule

// File: rtl/ijmp_eaddr.sv
module ijmp_eaddr #(
  parameter int ADDR_W  = 24,
  parameter int SHORT_W = 16
) (
  input  logic [ADDR_W-1:0]         pc,
  input  logic                      mode,
  input  logic [ADDR_W-SHORT_W-1:0] base,
  output logic [ADDR_W-1:0]         eaddr
);
  assign eaddr = mode ? pc : {base, pc[SHORT_W-1:0]};
endmodule

// File: rtl/ijmp_unit.sv
module ijmp_unit
  import ijmp_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int SHORT_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [BYTE_W-1:0]         in_data,
  input  logic [ADDR_W-1:0]         idx_a,
  input  logic [ADDR_W-1:0]         idx_b,
  input  logic [ADDR_W-SHORT_W-1:0] base_reg,
  input  logic                      mode_in,
  output logic [ADDR_W-1:0]         pc,
  output logic [ADDR_W-1:0]         fetch_addr,
  output logic                      mode_out,
  output logic                      jump_taken,
  output logic [CYC_W-1:0]          jump_cycles
);
  logic fire;
  logic use_b;
  pfx_e pfx;

  ijmp_decoder #(.BYTE_W(BYTE_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .fire       (fire),
    .fire_use_b (use_b),
    .fire_pfx   (pfx)
  );

  ijmp_pcgen #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .use_b   (use_b),
    .pfx     (pfx),
    .mode_in (mode_in),
    .idx_a   (idx_a),
    .idx_b   (idx_b),
    .pc_q    (pc),
    .mode_q  (mode_out),
    .taken_q (jump_taken),
    .cyc_q   (jump_cycles)
  );

  ijmp_eaddr #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_ea (
    .pc    (pc),
    .mode  (mode_out),
    .base  (base_reg),
    .eaddr (fetch_addr)
  );

  // R1: the cycle after reset the architectural state is cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pc == '0 && !mode_out && !jump_taken));
endmodule

// File: tb/ijmp_unit_test.sv
module ijmp_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic [23:0] idx_a = 24'h0;
  logic [23:0] idx_b = 24'h0;
  logic [7:0]  base_reg = 8'h0;
  logic        mode_in = 1'b0;
  logic [23:0] pc;
  logic [23:0] fetch_addr;
  logic        mode_out;
  logic        jump_taken;
  logic [2:0]  jump_cycles;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench model state
  int          m_st  = 0;  // 0 idle, 1 after prefix, 2 after selector
  int          m_pfx = 0;  // 0 none, 1 short, 2 long
  bit          m_b   = 0;
  logic [23:0] m_pc  = 0;
  bit          m_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ijmp_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .idx_a(idx_a), .idx_b(idx_b), .base_reg(base_reg),
    .mode_in(mode_in), .pc(pc), .fetch_addr(fetch_addr), .mode_out(mode_out),
    .jump_taken(jump_taken), .jump_cycles(jump_cycles)
  );

  function automatic logic [23:0] exp_ea(logic [23:0] p, bit m, logic [7:0] b);
    return m ? p : {b, p[15:0]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(pc == m_pc, {req, " pc"}, 32'(pc), 32'(m_pc));
    chk(mode_out == m_mode, {req, " mode"}, 32'(mode_out), 32'(m_mode));
    chk(fetch_addr == exp_ea(m_pc, m_mode, base_reg), "R7 fetch_addr",
        32'(fetch_addr), 32'(exp_ea(m_pc, m_mode, base_reg)));
  endtask

  // send one byte, update model, check outputs the cycle after acceptance
  task automatic send(logic [7:0] b, bit mi);
    bit fire = 0;
    int cyc = 0;
    @(negedge clk);
    in_valid = 1'b1; in_data = b; mode_in = mi;
    chk(in_ready == 1'b1, "R10 ready", 32'(in_ready), 32'd1);
    case (m_st)
      0: begin
        if (b == 8'h40) begin m_st = 1; m_pfx = 1; end
        else if (b == 8'h5B) begin m_st = 1; m_pfx = 2; end
        else if (b == 8'hDD || b == 8'hFD) begin m_st = 2; m_pfx = 0; m_b = (b == 8'hFD); end
      end
      1: begin
        if (b == 8'hDD || b == 8'hFD) begin m_st = 2; m_b = (b == 8'hFD); end
        else m_st = 0;
      end
      default: begin
        m_st = 0;
        fire = (b == 8'hE9);
      end
    endcase
    if (fire) begin
      logic [23:0] s = m_b ? idx_b : idx_a;
      bit lng = (m_pfx == 2) || (mi && m_pfx != 1);
      m_pc = lng ? s : {m_pc[23:16], s[15:0]};
      m_mode = lng;
      cyc = (m_pfx == 0) ? 4 : 5;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(jump_taken == fire, fire ? "R8 taken" : "R9 no taken", 32'(jump_taken), 32'(fire));
    if (fire) chk(jump_cycles == 3'(cyc), "R8 cycles", 32'(jump_cycles), 32'(cyc));
    check_state(fire ? "R2" : "R9");
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_data = 8'($urandom);
      chk(jump_taken == 1'b0, "R10 gap strobe", 32'(jump_taken), 32'd0);
      check_state("R10");
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R1 ready", 32'(in_ready), 32'd0);
    chk(pc == 24'h0, "R1 pc", 32'(pc), 32'd0);
    chk(mode_out == 1'b0, "R1 mode", 32'(mode_out), 32'd0);
    chk(jump_taken == 1'b0, "R1 taken", 32'(jump_taken), 32'd0);
    rst = 1'b0;
    m_st = 0; m_pfx = 0; m_pc = 0; m_mode = 0;
  endtask

  function automatic logic [7:0] pick_byte();
    int r = int'($urandom_range(0, 9));
    case (r)
      0, 1: return 8'hDD;
      2, 3: return 8'hFD;
      4, 5: return 8'hE9;
      6:    return 8'h40;
      7:    return 8'h5B;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    do_reset();
    base_reg = 8'hA5; idx_a = 24'h123456; idx_b = 24'hFEDCBA;
    // R3: mode 0 unprefixed via A, then short prefix via B
    send(8'hDD, 0); send(8'hE9, 0);
    send(8'h40, 0); send(8'hFD, 0); send(8'hE9, 0);
    // R5: mode 0 with long prefix
    send(8'h5B, 0); send(8'hDD, 0); send(8'hE9, 0);
    // R4: mode 1 unprefixed and long
    send(8'hFD, 1); send(8'hE9, 1);
    send(8'h5B, 1); send(8'hDD, 1); send(8'hE9, 1);
    // R6: mode 1 with short prefix keeps upper bits
    idx_b = 24'h77AA55;
    send(8'h40, 1); send(8'hFD, 1); send(8'hE9, 1);
    // R9: broken sequences
    send(8'hDD, 0); send(8'hDD, 0); send(8'hE9, 0);
    send(8'h40, 0); send(8'h40, 0); send(8'hDD, 0); send(8'hE9, 0);
    send(8'h5B, 1); send(8'hE9, 1);
    // R10: gaps inside a sequence
    send(8'h5B, 0); gap(3); send(8'hFD, 0); gap(2); send(8'hE9, 0);
    // R1: reset mid-sequence discards the pending selector
    send(8'hDD, 1);
    do_reset();
    send(8'hE9, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      idx_a = 24'($urandom); idx_b = 24'($urandom); base_reg = 8'($urandom);
      send(pick_byte(), 1'($urandom));
      if ($urandom_range(0, 3) == 0) gap(int'($urandom_range(1, 2)));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule